// File: doc/BRIEF.md
# Gated Serial Clock Output Divider

This block produces the serial clock that is sent out to external modulators. A select bit picks one of two source clocks, either the system clock or an audio clock. The selected source goes through a divide-by-(N+1) counter, where N is an 8-bit ratio field. A ratio of zero turns generation off and holds the output low.

A global interface enable gates the whole path. When the enable is cleared, the output goes low one system clock cycle later. The source select and the ratio are held in a small configuration register. That register takes writes only while the interface is disabled, so the divider never changes under a running clock. The stored ratio is also driven out as the threshold for a clock-absence detector that sits outside this block.

Top module: `sclk_out_gen`

## Requirements
- R1: While `en_i` is 0, a write on `cfg_we_i` stores `cfg_wdata_i[7:0]` as the ratio N and `cfg_wdata_i[8]` as the source select. The stored ratio appears on `thr_o` after the next `sys_clk_i` rising edge.
- R2: While `en_i` is 1, writes are ignored. `thr_o` keeps its value, and the output keeps the previously selected source and ratio.
- R3: With N = 0, `clk_o` stays low even while `en_i` is 1.
- R4: With N from 1 to 255 and the interface enabled, every `clk_o` period lasts N+1 cycles of the selected source clock.
- R5: Within each period, `clk_o` is high for floor((N+1)/2) source cycles and low for the remaining cycles.
- R6: Source select 0 divides `sys_clk_i`. Source select 1 divides `aud_clk_i`.
- R7: After `en_i` is sampled low on a `sys_clk_i` rising edge, `clk_o` is low from that edge on.
- R8: The counter restarts from zero after the enable rises, so the first high pulse after enabling has the full length floor((N+1)/2).
- R9: During reset, `clk_o` is low and `thr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | System clock; register and enable clock; source 0 |
| aud_clk_i | input | 1 | Audio clock; source 1 |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global interface enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 9 | Bit 8 source select, bits 7:0 ratio N |
| clk_o | output | 1 | Divided serial clock |
| thr_o | output | 8 | Stored ratio, exported as the absence threshold |

## Verification
The bench builds the block with the default 8-bit ratio. With that width, every ratio from 0 to 255 can be swept on the system clock. A stepped subset of ratios is run on the audio clock, which runs at a period unrelated to the system clock. Period and high time are counted in cycles of the selected source. This exposes off-by-one errors in the counter and in the duty split for odd ratios. Directed sequences cover the write lock, the first pulse after enabling, and the one-cycle shutdown.

// File: rtl/sclk_out_pkg.sv
package sclk_out_pkg;
  localparam int unsigned DIV_W = 8;

  typedef struct packed {
    logic             sel;
    logic [DIV_W-1:0] div;
  } sclk_cfg_t;
endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg
  import sclk_out_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [DIV_W:0]   wdata_i,
  output sclk_cfg_t        cfg_o,
  output logic             en_q_o
);
  sclk_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      en_q_o <= 1'b0;
    end else begin
      en_q_o <= en_i;
      if (we_i && !en_i) cfg_q <= wdata_i;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/sclk_en_sync.sv
module sclk_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/sclk_div_cnt.sv
module sclk_div_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] div_i,
  output logic         clk_o
);
  localparam int unsigned HW = W + 1;

  logic [W-1:0]  cnt_q;
  logic [HW-1:0] half;
  logic          active;

  assign half   = ({1'b0, div_i} + HW'(1)) >> 1;
  assign active = run_i && (div_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else if (!active) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + W'(1);
      clk_o <= ({1'b0, cnt_q} < half);
    end
  end
endmodule

// File: rtl/sclk_out_gen.sv
module sclk_out_gen
  import sclk_out_pkg::*;
(
  input  logic             sys_clk_i,
  input  logic             aud_clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cfg_we_i,
  input  logic [DIV_W:0]   cfg_wdata_i,
  output logic             clk_o,
  output logic [DIV_W-1:0] thr_o
);
  sclk_cfg_t cfg;
  logic      en_q;
  logic      src_clk;
  logic      run_src;
  logic      div_clk;

  sclk_cfg_reg u_cfg (
    .clk_i   (sys_clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .en_q_o  (en_q)
  );

  // select is static while enabled, counter idle when it may change
  assign src_clk = cfg.sel ? aud_clk_i : sys_clk_i;

  sclk_en_sync #(.STAGES(2)) u_sync (
    .clk_i  (src_clk),
    .rst_ni (rst_ni),
    .d_i    (en_q),
    .q_o    (run_src)
  );

  sclk_div_cnt #(.W(DIV_W)) u_cnt (
    .clk_i  (src_clk),
    .rst_ni (rst_ni),
    .run_i  (run_src),
    .div_i  (cfg.div),
    .clk_o  (div_clk)
  );

  assign clk_o = div_clk & en_q;
  assign thr_o = cfg.div;
endmodule

// File: rtl/sclk_out_chk.sv
module sclk_out_chk
  import sclk_out_pkg::*;
(
  input logic             sys_clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             cfg_we_i,
  input logic [DIV_W:0]   cfg_wdata_i,
  input logic             clk_o,
  input logic [DIV_W-1:0] thr_o
);
  assert_write_open_R1: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (cfg_we_i && !en_i) |=> (thr_o == $past(cfg_wdata_i[DIV_W-1:0])));

  assert_write_locked_R2: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (cfg_we_i && en_i) |=> $stable(thr_o));

  assert_zero_ratio_low_R3: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (thr_o == '0) |-> !clk_o);

  assert_disable_low_R7: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !en_i |=> !clk_o);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_state_R9: assert (!clk_o && thr_o == '0);
    end
  end
endmodule

bind sclk_out_gen sclk_out_chk u_chk (
  .sys_clk_i   (sys_clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .clk_o       (clk_o),
  .thr_o       (thr_o)
);

// File: tb/sclk_out_gen_tb.sv
module sclk_out_gen_tb_top;
  logic       sys_clk = 1'b0;
  logic       aud_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       en      = 1'b0;
  logic       we      = 1'b0;
  logic [8:0] wdata   = '0;
  logic       clk_out;
  logic [7:0] thr;
  logic       sel_tb  = 1'b0;
  int         total   = 0;
  int         bad     = 0;

  always #10 sys_clk = ~sys_clk;
  always #7  aud_clk = ~aud_clk;

  sclk_out_gen dut_i (
    .sys_clk_i   (sys_clk),
    .aud_clk_i   (aud_clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .clk_o       (clk_out),
    .thr_o       (thr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [7:0] n);
    @(negedge sys_clk);
    we = 1'b1; wdata = {sel, n};
    @(negedge sys_clk);
    we = 1'b0;
  endtask

  task automatic sample(output logic v);
    if (sel_tb) @(negedge aud_clk);
    else        @(negedge sys_clk);
    v = clk_out;
  endtask

  // first high run, then one full period measured in source cycles
  task automatic measure(output int fh, output int hi, output int per);
    logic v;
    int   g, lo;
    fh = 0; hi = 0; lo = 0; per = 0;
    g = 0;
    do begin sample(v); g++; end while (!v && g < 2000);
    while (v && fh < 2000) begin fh++; sample(v); end
    g = 0;
    while (!v && g < 2000) begin g++; sample(v); end
    while (v && hi < 2000) begin hi++; sample(v); end
    while (!v && lo < 2000) begin lo++; sample(v); end
    per = hi + lo;
  endtask

  task automatic run_ratio(input logic sel, input int n);
    int fh, hi, per;
    sel_tb = sel;
    cfg_write(sel, 8'(n));
    check(thr == 8'(n), "R1", thr, n);
    @(negedge sys_clk); en = 1'b1;
    measure(fh, hi, per);
    check(fh == (n + 1) / 2, "R8", fh, (n + 1) / 2);
    check(hi == (n + 1) / 2, "R5", hi, (n + 1) / 2);
    check(per == n + 1, sel ? "R6" : "R4", per, n + 1);
    @(negedge sys_clk); en = 1'b0;
    repeat (8) @(negedge sys_clk);
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int   lowcnt;
    logic v;
    repeat (3) @(negedge sys_clk);
    check(clk_out == 1'b0, "R9", clk_out, 0);
    check(thr == 8'd0, "R9", thr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge sys_clk);

    // R3: zero ratio stays low when enabled
    cfg_write(1'b0, 8'd0);
    en = 1'b1;
    lowcnt = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge sys_clk);
      if (!clk_out) lowcnt++;
    end
    check(lowcnt == 50, "R3", lowcnt, 50);
    en = 1'b0;
    repeat (4) @(negedge sys_clk);

    // R4/R5/R8 on system clock, full sweep
    for (int n = 1; n < 256; n++) run_ratio(1'b0, n);
    // R6 audio clock, stepped sweep
    for (int n = 1; n < 256; n += 17) run_ratio(1'b1, n);
    run_ratio(1'b1, 255);

    // R2: writes ignored while enabled
    sel_tb = 1'b0;
    cfg_write(1'b0, 8'd3);
    @(negedge sys_clk); en = 1'b1;
    cfg_write(1'b1, 8'd7);
    check(thr == 8'd3, "R2", thr, 3);
    begin
      int fh, hi, per;
      measure(fh, hi, per);
      check(per == 4, "R2", per, 4);
    end
    @(negedge sys_clk); en = 1'b0;
    repeat (8) @(negedge sys_clk);

    // R7: drop enable mid high phase
    cfg_write(1'b0, 8'd255);
    @(negedge sys_clk); en = 1'b1;
    do begin
      @(negedge sys_clk); v = clk_out;
    end while (!v);
    repeat (5) @(negedge sys_clk);
    en = 1'b0;
    #1;
    check(clk_out == 1'b1, "R7", clk_out, 1);
    @(negedge sys_clk);
    check(clk_out == 1'b0, "R7", clk_out, 0);
    repeat (8) @(negedge sys_clk);
    cfg_write(1'b0, 8'd9);
    check(thr == 8'd9, "R1", thr, 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule